// File: doc/BRIEF.md
# Preloadable Sliced-Width Memory Block

This block is an 8192-bit single-port memory that stores its data in a 1024-row by 8-bit array. Configuration inputs choose how wide a logical word is: 1, 2, 4 or 8 bits, which gives 8192, 4096, 2048 or 1024 words. In the narrower shapes the low address bits pick one slice of a stored byte. That slice is the only part read out, and the only part changed by a write.

The array is filled with a computed pattern when the device is configured, so it never holds unknown data. This lets the block act as a lookup table or a ROM. A ROM switch blocks every write. Read data comes straight from the array, or it can pass through an output register that has an asynchronous clear. The write side and the output register each take their clock from one of four global clocks or a local clock, chosen by parameter.

Top module: `initmem_block`

## Requirements
- R1: After configuration, the byte stored in row r equals (r*INIT_MUL + INIT_ADD) mod 256. The defaults are INIT_MUL=37 and INIT_ADD=5.
- R2: cfg_width encodes the word width: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits. For width 2^k, the row is addr[12-k:3-k] and the lane is addr[2-k:0]. Address bits above 12-k are ignored.
- R3: Reading a lane of width N returns byte bits [lane*N +: N] on dout[N-1:0], with lane 0 at the least significant end. All dout bits above N-1 read as zero.
- R4: When wr_en is high and cfg_rom is low, the rising edge of the write clock replaces the selected lane of the addressed row with din[N-1:0]. All other bits of that row keep their value.
- R5: While cfg_rom is high, wr_en has no effect on the stored contents.
- R6: With cfg_outreg low, dout follows addr and cfg_width combinationally, with no clock edge needed.
- R7: With cfg_outreg high, dout changes only on the rising edge of the output clock. At that edge it loads the data read before the edge, so a write to the same location on the same edge shows up one edge later.
- R8: When rst is high, the output register clears to zero at once, without waiting for a clock edge. With cfg_outreg high, dout then reads zero.
- R9: The parameters WR_CLK_SEL and RD_CLK_SEL pick the write clock and the output clock: values 0 to 3 select gclk[0] to gclk[3], and value 4 selects lclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high asynchronous clear of the output register |
| gclk | input | 4 | Global clock candidates |
| lclk | input | 1 | Local clock candidate |
| cfg_width | input | 2 | Word width code (R2) |
| cfg_rom | input | 1 | High blocks all writes |
| cfg_outreg | input | 1 | High routes reads through the output register |
| wr_en | input | 1 | Write request |
| addr | input | 13 | Word address |
| din | input | 8 | Write data, lane value in the low bits |
| dout | output | 8 | Read data, lane value in the low bits |

## Verification
A write and a registered read can hit the same row on the same clock edge. The bench triggers this by enabling the output register, pointing the address at a row with a known preload value, and raising wr_en with different data in the same cycle. The output after that edge must still show the preload byte, and the new byte must appear only after the next edge, because the register captures the value read before the edge. A second overlap, a narrow-lane write landing inside a byte that other lanes share, is judged by reading back the whole byte in 8-bit mode.

// File: rtl/initmem_pkg.sv
package initmem_pkg;

  // Width codes: word width is 2**code bits
  localparam int unsigned WCODE_W = 2;

  typedef enum logic [WCODE_W-1:0] {
    WID_X1 = 2'd0,
    WID_X2 = 2'd1,
    WID_X4 = 2'd2,
    WID_X8 = 2'd3
  } width_e;

  // Index of the clock candidate that means "local clock"
  localparam int unsigned NUM_GCLK = 4;
  localparam int unsigned SEL_LOCAL = NUM_GCLK;

  // Preload pattern for one row
  function automatic int unsigned preload_value(int unsigned row, int unsigned mul,
                                                int unsigned add);
    return row * mul + add;
  endfunction

endpackage

// File: rtl/initmem_clksel.sv
module initmem_clksel #(
  parameter int unsigned NUM_G = 4,
  parameter int unsigned SEL   = 0
) (
  input  logic [NUM_G-1:0] gclk,
  input  logic             lclk,
  output logic             clk_o
);

  generate
    if (SEL >= NUM_G) begin : g_local
      assign clk_o = lclk;
    end else begin : g_global
      assign clk_o = gclk[SEL];
    end
  endgenerate

endmodule

// File: rtl/initmem_addrmap.sv
module initmem_addrmap #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 3,
  parameter int unsigned CODE_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] width,
  input  logic [DATA_W-1:0] din,
  output logic [ROW_W-1:0]  row,
  output logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] wdata
);

  int unsigned k_i;
  int unsigned lb_i;
  int unsigned n_i;
  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] low_bits;

  always_comb begin
    k_i = int'(width);
    if (k_i > LANE_W) k_i = LANE_W;
    lb_i = LANE_W - k_i;
    n_i  = 1 << k_i;
    shifted  = addr >> lb_i;
    row      = shifted[ROW_W-1:0];
    low_bits = addr & ((ADDR_W'(1) << lb_i) - ADDR_W'(1));
    lane     = low_bits[LANE_W-1:0];
    for (int b = 0; b < DATA_W; b++) begin
      mask[b]  = ((b / n_i) == int'(lane));
      wdata[b] = din[b % n_i];
    end
  end

endmodule

// File: rtl/initmem_array.sv
module initmem_array #(
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned INIT_MUL = 37,
  parameter int unsigned INIT_ADD = 5
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  import initmem_pkg::*;

  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Configuration-time preload
  initial begin
    for (int r = 0; r < DEPTH; r++) begin
      mem[r] = DATA_W'(preload_value(r, INIT_MUL, INIT_ADD));
    end
  end

  // Bit-enabled write
  always_ff @(posedge wclk) begin
    if (we) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (mask[b]) mem[row][b] <= wdata[b];
      end
    end
  end

  assign rdata = mem[row];

endmodule

// File: rtl/initmem_rdpath.sv
module initmem_rdpath #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 3,
  parameter int unsigned CODE_W = 2
) (
  input  logic              oclk,
  input  logic              rst,
  input  logic [CODE_W-1:0] width,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] rbyte,
  input  logic              outreg,
  output logic [DATA_W-1:0] slice,
  output logic [DATA_W-1:0] dout
);

  int unsigned k_i;
  int unsigned n_i;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    k_i = int'(width);
    if (k_i > LANE_W) k_i = LANE_W;
    n_i     = 1 << k_i;
    shifted = rbyte >> (int'(lane) * n_i);
    slice   = shifted & ((DATA_W'(1) << n_i) - DATA_W'(1));
  end

  always_ff @(posedge oclk or posedge rst) begin
    if (rst) dout_q <= '0;
    else     dout_q <= slice;
  end

  assign dout = outreg ? dout_q : slice;

endmodule

// File: rtl/initmem_block.sv
module initmem_block #(
  parameter int unsigned ROW_W      = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned INIT_MUL   = 37,
  parameter int unsigned INIT_ADD   = 5,
  parameter int unsigned WR_CLK_SEL = 4,
  parameter int unsigned RD_CLK_SEL = 4,
  localparam int unsigned LANE_W    = $clog2(DATA_W),
  localparam int unsigned ADDR_W    = ROW_W + LANE_W,
  localparam int unsigned CODE_W    = $clog2(LANE_W + 1),
  localparam int unsigned NG        = initmem_pkg::NUM_GCLK
) (
  input  logic              rst,
  input  logic [NG-1:0]     gclk,
  input  logic              lclk,
  input  logic [CODE_W-1:0] cfg_width,
  input  logic              cfg_rom,
  input  logic              cfg_outreg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic              wclk;
  logic              oclk;
  logic [ROW_W-1:0]  row;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] rd_slice;
  logic              we_gated;

  initmem_clksel #(.NUM_G(NG), .SEL(WR_CLK_SEL)) u_wsel (
    .gclk(gclk), .lclk(lclk), .clk_o(wclk)
  );

  initmem_clksel #(.NUM_G(NG), .SEL(RD_CLK_SEL)) u_rsel (
    .gclk(gclk), .lclk(lclk), .clk_o(oclk)
  );

  initmem_addrmap #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W),
    .LANE_W(LANE_W), .CODE_W(CODE_W)
  ) u_map (
    .addr(addr), .width(cfg_width), .din(din),
    .row(row), .lane(lane), .mask(mask), .wdata(wdata)
  );

  assign we_gated = wr_en & ~cfg_rom;

  initmem_array #(
    .ROW_W(ROW_W), .DATA_W(DATA_W),
    .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)
  ) u_mem (
    .wclk(wclk), .we(we_gated), .row(row),
    .mask(mask), .wdata(wdata), .rdata(rd_byte)
  );

  initmem_rdpath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CODE_W(CODE_W)) u_rd (
    .oclk(oclk), .rst(rst), .width(cfg_width), .lane(lane),
    .rbyte(rd_byte), .outreg(cfg_outreg), .slice(rd_slice), .dout(dout)
  );

endmodule

// File: rtl/initmem_block_chk.sv
module initmem_block_chk #(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 2
) (
  input logic              wclk,
  input logic              oclk,
  input logic              rst,
  input logic [CODE_W-1:0] cfg_width,
  input logic              cfg_rom,
  input logic              cfg_outreg,
  input logic              wr_en,
  input logic [ROW_W-1:0]  row,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] rd_byte,
  input logic [DATA_W-1:0] rd_slice,
  input logic [DATA_W-1:0] dout
);

  logic first_seen;
  logic [DATA_W-1:0] above;

  always_ff @(posedge oclk or posedge rst) begin
    if (rst) first_seen <= 1'b0;
    else     first_seen <= 1'b1;
  end

  always_comb above = dout >> (1 << int'(cfg_width));

  // R4: a write leaves unselected bits of the row untouched
  p_keep_lanes_r4: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && !cfg_rom) |=>
      ((row != $past(row)) || (((rd_byte ^ $past(rd_byte)) & ~$past(mask)) == '0)));

  // R5: ROM mode freezes contents
  p_rom_frozen_r5: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && cfg_rom) |=> ((row != $past(row)) || (rd_byte == $past(rd_byte))));

  // R3: bits above the word width read zero
  p_upper_zero_r3: assert property (@(posedge oclk) disable iff (rst)
    (!cfg_outreg) |-> (above == '0));

  // R7: registered output shows the value read before the previous edge
  p_reg_delay_r7: assert property (@(posedge oclk) disable iff (rst)
    (first_seen && cfg_outreg) |-> (dout == $past(rd_slice)));

  // R8: output register is zero up to the first edge after reset
  p_reset_clear_r8: assert property (@(posedge oclk) disable iff (rst)
    (!first_seen && cfg_outreg) |-> (dout == '0));

endmodule

bind initmem_block initmem_block_chk #(
  .ROW_W(ROW_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
) u_chk (
  .wclk(wclk), .oclk(oclk), .rst(rst), .cfg_width(cfg_width),
  .cfg_rom(cfg_rom), .cfg_outreg(cfg_outreg), .wr_en(wr_en),
  .row(row), .mask(mask), .rd_byte(rd_byte), .rd_slice(rd_slice), .dout(dout)
);

// File: tb/initmem_block_test.sv
module initmem_block_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] gclk;
  logic       lclk;
  logic [1:0] cfg_width = 2'd3;
  logic       cfg_rom = 1'b0;
  logic       cfg_outreg = 1'b1;
  logic       wr_en = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // R9: write side on lclk, output register on gclk[2]; the other globals stay low
  assign gclk = {1'b0, clk, 1'b0, 1'b0};
  assign lclk = clk;

  initmem_block #(.WR_CLK_SEL(4), .RD_CLK_SEL(2)) uut (
    .rst(rst), .gclk(gclk), .lclk(lclk), .cfg_width(cfg_width),
    .cfg_rom(cfg_rom), .cfg_outreg(cfg_outreg), .wr_en(wr_en),
    .addr(addr), .din(din), .dout(dout)
  );

  // {width code, address, expected dout} read against the R1 preload pattern
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {2'd3, 13'h0001, 8'h2A}, {2'd3, 13'h1FFF, 8'hE0}, {2'd3, 13'h0402, 8'h4F},
    {2'd2, 13'h0005, 8'h04}, {2'd2, 13'h0004, 8'h0F}, {2'd2, 13'h1002, 8'h0A},
    {2'd1, 13'h0007, 8'h00}, {2'd1, 13'h0005, 8'h02}, {2'd1, 13'h001D, 8'h02},
    {2'd0, 13'h0016, 8'h01}, {2'd0, 13'h0015, 8'h00}, {2'd0, 13'h1FFF, 8'h01},
    {2'd0, 13'h1FF8, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: dout=%02h expected %02h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic write_lane(input logic [1:0] w, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_width = w; addr = a; din = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic comb_read(input string req, input logic [1:0] w, input logic [12:0] a,
                           input logic [7:0] exp);
    @(negedge clk);
    cfg_width = w; addr = a;
    #1 check(req, dout, exp);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: dout=%02h expected run to end", dout);
    finish_run();
  end

  initial begin
    // R8: reset state of the registered output
    #2 check("R8 reset state", dout, 8'h00);
    @(negedge clk); rst = 1'b0;

    // Table walk, combinational reads (R1 R2 R3 R6)
    cfg_outreg = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_width = VEC[i][22:21]; addr = VEC[i][20:8];
      #1 check("R1/R2/R3 table", dout, VEC[i][7:0]);
    end

    // R6: output follows the address between clock edges
    @(posedge clk); #2;
    addr = 13'h0002; cfg_width = 2'd3;
    #1 check("R6 comb follow", dout, 8'h4F);

    // R4: 2-bit write into lane 2 of row 5 (0xBE -> 0x9E)
    write_lane(2'd1, 13'd22, 8'h01);
    comb_read("R4 x2 lane merge", 2'd3, 13'd5, 8'h9E);
    comb_read("R4 x2 lane readback", 2'd1, 13'd22, 8'h01);

    // R4: 1-bit write into lane 0 of row 9 (0x52 -> 0x53)
    write_lane(2'd0, 13'd72, 8'hFF);
    comb_read("R4 x1 bit merge", 2'd3, 13'd9, 8'h53);

    // R4: 4-bit write into lane 1 of row 0 (0x05 -> 0xA5)
    write_lane(2'd2, 13'd1, 8'h0A);
    comb_read("R4 x4 nibble merge", 2'd3, 13'd0, 8'hA5);

    // R5: ROM mode blocks writes
    cfg_rom = 1'b1;
    write_lane(2'd3, 13'd5, 8'h00);
    comb_read("R5 rom lockout", 2'd3, 13'd5, 8'h9E);
    cfg_rom = 1'b0;

    // R7: registered read and write of row 3 on the same edge
    @(negedge clk);
    cfg_outreg = 1'b1; cfg_width = 2'd3; addr = 13'd3; din = 8'h55; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1 check("R7 read-before-write", dout, 8'h74);
    @(negedge clk);
    #1 check("R7 new data next edge", dout, 8'h55);
    addr = 13'd0;
    #1 check("R7 hold between edges", dout, 8'h55);
    @(negedge clk);
    #1 check("R7 registered update (R9 clocks)", dout, 8'hA5);

    // R8: asynchronous clear with no clock edge
    @(negedge clk); rst = 1'b1;
    #1 check("R8 async clear", dout, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    #1 check("R8 reload after clear", dout, 8'hA5);

    finish_run();
  end

endmodule